// File: doc/BRIEF.md
# Page-Buffered Byte-Wide Nonvolatile Write Controller

This block models the write path of a byte-wide nonvolatile memory in synchronous logic. It takes active-low chip-select, read-enable and write-strobe inputs, a 16-bit address and an 8-bit data bus. The strobes must already be synchronous to `clk`. Each valid write strobe deposits one byte into a 128-byte staging page. The session stays open as long as each new write strobe arrives before a load window expires. When the window runs out, a self-timed programming phase copies the staged bytes into a behavioural storage array.

While programming is under way, a read does not return array contents. It returns a status byte: the top bit is the inverse of the top bit of the last byte loaded, the next bit alternates on every read, and the remaining bits are zero. This lets a host poll for completion in either of two ways. Once programming ends, reads return stored data again. The storage array covers the lowest 2^ARR_AW bytes of the address space, and higher addresses alias onto it.

Top module: `pgb_eeprom_ctrl`

## Requirements
- R1: A byte load starts only while chip-select is low, write-strobe is low and read-enable is high. A strobe with read-enable low, or with chip-select high, loads nothing and opens no session.
- R2: The byte address is taken when the later of chip-select and write-strobe goes low. The data byte is the value present in the last cycle before the earlier of the two returns high.
- R3: A write access active for fewer than GLITCH_MIN clock cycles is discarded. One active for GLITCH_MIN cycles or more is loaded.
- R4: Address bits 15:7 name the page and bits 6:0 the byte within it. The first load of a session fixes the page. A later load that names another page is dropped, and `page_err` goes high and stays high until reset.
- R5: Programming starts once LOAD_WIN cycles pass with no new write-strobe fall in the open session. `busy` rises LOAD_WIN+1 to LOAD_WIN+2 cycles after the last fall.
- R6: `busy` stays high for exactly PROG_CYC cycles. Write accesses made while it is high are ignored.
- R7: Programming writes only the byte positions loaded in the session. Every other byte of that page keeps its earlier value.
- R8: A read started while programming returns the inverse of bit 7 of the last loaded byte on `dout[7]`, and zero on `dout[5:0]`.
- R9: During programming, `dout[6]` differs between successive status reads. After programming ends, reads return stored data, including the new value of the last loaded byte.
- R10: Outside programming, a read returns the stored byte at its address on `dout` two clock edges after the registered read start. `dout_en` follows (chip-select low and read-enable low) delayed by two cycles.
- R11: After reset `busy`, `page_err`, `dout_en` and `dout` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 16 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data or status byte |
| dout_en | output | 1 | Read output active |
| busy | output | 1 | Programming phase in progress |
| page_err | output | 1 | Sticky off-page load flag |

## Verification
The assertions assume that the strobe inputs are already synchronous and are held at their inactive levels during reset. They also assume that a status read ends before the next one starts, so each read produces exactly one status byte. The bench drives every access from the falling clock edge. It holds each strobe for a whole number of cycles and spaces write accesses well inside the load window. It starts reads only when the previous read has fully ended, so these assumptions hold throughout.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pgb_strobe.sv
// Registers the bus, decodes read/write accesses, filters short write
// pulses and captures address (access start) and data (access end).
module pgb_strobe #(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int ARR_AW     = 11,
  parameter int GLITCH_MIN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     din,
  output logic              wr_start,
  output logic              wr_hold,
  output logic              ld_vld,
  output logic [AW-1:0]     ld_addr,
  output logic [DW-1:0]     ld_data,
  output logic              rd_act,
  output logic              rd_go,
  output logic [ARR_AW-1:0] rd_addr
);
  localparam int GW = $clog2(GLITCH_MIN + 1);

  logic          s_ce_n, s_oe_n, s_we_n;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_din;
  logic          wr_act, wr_q, rd_q, wr_end;
  logic [GW-1:0] gcnt;
  logic [AW-1:0] a_lat;
  logic [DW-1:0] d_lat;

  assign wr_act   = !s_ce_n && !s_we_n && s_oe_n;
  assign rd_act   = !s_ce_n && !s_oe_n;
  assign wr_start = wr_act && !wr_q;
  assign wr_end   = !wr_act && wr_q;
  assign wr_hold  = wr_act || wr_q;
  assign rd_go    = rd_act && !rd_q;
  assign rd_addr  = s_addr[ARR_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ce_n  <= 1'b1;
      s_oe_n  <= 1'b1;
      s_we_n  <= 1'b1;
      s_addr  <= '0;
      s_din   <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      gcnt    <= '0;
      a_lat   <= '0;
      d_lat   <= '0;
      ld_vld  <= 1'b0;
      ld_addr <= '0;
      ld_data <= '0;
    end else begin
      s_ce_n <= ce_n;
      s_oe_n <= oe_n;
      s_we_n <= we_n;
      s_addr <= addr;
      s_din  <= din;
      wr_q   <= wr_act;
      rd_q   <= rd_act;
      if (wr_start) begin
        gcnt  <= GW'(1);
        a_lat <= s_addr;
      end else if (wr_act && gcnt != GW'(GLITCH_MIN)) begin
        gcnt <= gcnt + GW'(1);
      end
      if (wr_act) d_lat <= s_din;
      ld_vld <= wr_end && (gcnt >= GW'(GLITCH_MIN));
      if (wr_end) begin
        ld_addr <= a_lat;
        ld_data <= d_lat;
      end
    end
  end
endmodule

// File: rtl/pgb_page_buf.sv
// Staging page: one write port for loads, one registered read port for
// the commit walk, and a per-byte loaded flag.
module pgb_page_buf #(
  parameter int DW      = 8,
  parameter int PAGE_AW = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [PAGE_AW-1:0] widx,
  input  logic [DW-1:0]      wdata,
  input  logic [PAGE_AW-1:0] ridx,
  output logic [DW-1:0]      rdata,
  output logic               rvld,
  input  logic               clr
);
  localparam int PAGE = 1 << PAGE_AW;

  logic [DW-1:0]   mem [PAGE];
  logic [PAGE-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      rvld <= 1'b0;
    end else begin
      rvld <= vld[ridx];
      if (clr) vld <= '0;
      else if (we) vld[widx] <= 1'b1;
    end
  end
endmodule

// File: rtl/pgb_array.sv
// Behavioural storage: simple dual port, registered read.
module pgb_array #(
  parameter int DW     = 8,
  parameter int ARR_AW = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ARR_AW-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic              re,
  input  logic [ARR_AW-1:0] raddr,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << ARR_AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgb_seq.sv
// Session sequencer: page lock, load window, program timer, commit walk.
module pgb_seq
  import pgb_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int PAGE_AW  = 7,
  parameter int ARR_AW   = 11,
  parameter int LOAD_WIN = 12500,
  parameter int PROG_CYC = 1250000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_start,
  input  logic               wr_hold,
  input  logic               ld_vld,
  input  logic [AW-1:0]      ld_addr,
  input  logic [DW-1:0]      ld_data,
  output logic               buf_we,
  output logic [PAGE_AW-1:0] buf_widx,
  output logic [DW-1:0]      buf_wdata,
  output logic [PAGE_AW-1:0] buf_ridx,
  output logic               buf_clr,
  input  logic               buf_rvld,
  input  logic [DW-1:0]      buf_rdata,
  output logic               arr_we,
  output logic [ARR_AW-1:0]  arr_waddr,
  output logic [DW-1:0]      arr_wdata,
  output logic               busy,
  output logic               page_err,
  output logic               last_b7
);
  localparam int PGW  = AW - PAGE_AW;
  localparam int PAGE = 1 << PAGE_AW;
  localparam int WW   = $clog2(LOAD_WIN + 1);
  localparam int PCW  = $clog2(PROG_CYC + 1);

  seq_state_e         state;
  logic [WW-1:0]      win;
  logic [PCW-1:0]     pcnt;
  logic [PGW-1:0]     page_q;
  logic [PGW-1:0]     ld_page;
  logic               hit, accept, timeout, cm_act, prog_end;
  logic               cm_act_q;
  logic [PAGE_AW-1:0] cm_idx_q;

  assign ld_page  = ld_addr[AW-1:PAGE_AW];
  assign hit      = (ld_page == page_q);
  assign accept   = ld_vld && ((state == ST_IDLE) || (state == ST_LOAD && hit));
  assign timeout  = (state == ST_LOAD) && !ld_vld && !wr_hold &&
                    (win >= WW'(LOAD_WIN - 1));
  assign cm_act   = (state == ST_PROG) && (pcnt < PCW'(PAGE));
  assign prog_end = (state == ST_PROG) && (pcnt == PCW'(PROG_CYC - 1));

  assign buf_we    = accept;
  assign buf_widx  = ld_addr[PAGE_AW-1:0];
  assign buf_wdata = ld_data;
  assign buf_ridx  = pcnt[PAGE_AW-1:0];
  assign buf_clr   = prog_end;

  assign arr_we    = cm_act_q && buf_rvld;
  assign arr_waddr = ARR_AW'({page_q, cm_idx_q});
  assign arr_wdata = buf_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      win      <= '0;
      pcnt     <= '0;
      page_q   <= '0;
      page_err <= 1'b0;
      busy     <= 1'b0;
      last_b7  <= 1'b0;
      cm_act_q <= 1'b0;
      cm_idx_q <= '0;
    end else begin
      if (wr_start) win <= '0;
      else if (win != WW'(LOAD_WIN)) win <= win + WW'(1);
      cm_act_q <= cm_act;
      cm_idx_q <= buf_ridx;
      case (state)
        ST_IDLE: begin
          if (ld_vld) begin
            page_q  <= ld_page;
            last_b7 <= ld_data[DW-1];
            state   <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (ld_vld) begin
            if (hit) last_b7 <= ld_data[DW-1];
            else     page_err <= 1'b1;
          end else if (timeout) begin
            state <= ST_PROG;
            busy  <= 1'b1;
            pcnt  <= '0;
          end
        end
        ST_PROG: begin
          if (prog_end) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end else begin
            pcnt <= pcnt + PCW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgb_eeprom_ctrl.sv
// Top: page-buffered write controller with polling status readout.
// PROG_CYC must be at least 2^PAGE_AW + 2.
module pgb_eeprom_ctrl #(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int PAGE_AW    = 7,
  parameter int ARR_AW     = 11,
  parameter int LOAD_WIN   = 12500,
  parameter int PROG_CYC   = 1250000,
  parameter int GLITCH_MIN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          busy,
  output logic          page_err
);
  logic               wr_start, wr_hold, ld_vld, rd_act, rd_go;
  logic [AW-1:0]      ld_addr;
  logic [DW-1:0]      ld_data;
  logic [ARR_AW-1:0]  rd_addr;
  logic               buf_we, buf_clr, buf_rvld;
  logic [PAGE_AW-1:0] buf_widx, buf_ridx;
  logic [DW-1:0]      buf_wdata, buf_rdata;
  logic               arr_we;
  logic [ARR_AW-1:0]  arr_waddr;
  logic [DW-1:0]      arr_wdata, arr_rdata;
  logic               last_b7;

  logic go_d, stat_d, b7_d, tog_d, tog;

  pgb_strobe #(.AW(AW), .DW(DW), .ARR_AW(ARR_AW), .GLITCH_MIN(GLITCH_MIN)) u_strobe (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .wr_start(wr_start), .wr_hold(wr_hold),
    .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_act(rd_act), .rd_go(rd_go), .rd_addr(rd_addr)
  );

  pgb_seq #(.AW(AW), .DW(DW), .PAGE_AW(PAGE_AW), .ARR_AW(ARR_AW),
            .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_hold(wr_hold),
    .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_data(ld_data),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
    .buf_ridx(buf_ridx), .buf_clr(buf_clr), .buf_rvld(buf_rvld),
    .buf_rdata(buf_rdata), .arr_we(arr_we), .arr_waddr(arr_waddr),
    .arr_wdata(arr_wdata), .busy(busy), .page_err(page_err), .last_b7(last_b7)
  );

  pgb_page_buf #(.DW(DW), .PAGE_AW(PAGE_AW)) u_buf (
    .clk(clk), .rst(rst), .we(buf_we), .widx(buf_widx), .wdata(buf_wdata),
    .ridx(buf_ridx), .rdata(buf_rdata), .rvld(buf_rvld), .clr(buf_clr)
  );

  pgb_array #(.DW(DW), .ARR_AW(ARR_AW)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .re(rd_go), .raddr(rd_addr), .rdata(arr_rdata)
  );

  // Read pipeline: stage 1 launches the array read and snapshots status,
  // stage 2 selects status or array data into the output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      go_d    <= 1'b0;
      stat_d  <= 1'b0;
      b7_d    <= 1'b0;
      tog_d   <= 1'b0;
      tog     <= 1'b0;
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      go_d    <= rd_go;
      dout_en <= rd_act;
      if (rd_go) begin
        stat_d <= busy;
        b7_d   <= ~last_b7;
        tog_d  <= tog;
        if (busy) tog <= ~tog;
      end
      if (go_d) begin
        if (stat_d) dout <= {b7_d, tog_d, {(DW-2){1'b0}}};
        else        dout <= arr_rdata;
      end
    end
  end
endmodule

// File: rtl/pgb_checker.sv
module pgb_checker #(
  parameter int DW       = 8,
  parameter int PROG_CYC = 1250000
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          oe_n,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic          busy,
  input logic          page_err
);
  logic [31:0] bcnt;
  logic [1:0]  sr;
  logic        den_q, busy_q, stat1, have_tog, last_tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt     <= '0;
      sr       <= '0;
      den_q    <= 1'b0;
      busy_q   <= 1'b0;
      stat1    <= 1'b0;
      have_tog <= 1'b0;
      last_tog <= 1'b0;
    end else begin
      bcnt   <= busy ? bcnt + 32'd1 : 32'd0;
      if (sr != 2'd3) sr <= sr + 2'd1;
      den_q  <= dout_en;
      busy_q <= busy;
      stat1  <= dout_en && !den_q && busy_q;
      if (stat1) begin
        have_tog <= 1'b1;
        last_tog <= dout[DW-2];
      end
    end
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == 32'(PROG_CYC)));

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sr == 2'd3 && $past(page_err)) |-> page_err);

  // R8
  poll_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stat1 |-> (dout[DW-3:0] == '0));

  // R9
  toggle_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (stat1 && have_tog) |-> (dout[DW-2] != last_tog));

  // R10
  oe_track_chk: assert property (@(posedge clk) disable iff (rst)
    (sr == 2'd3) |-> (dout_en == $past(!ce_n && !oe_n, 2)));
endmodule

bind pgb_eeprom_ctrl pgb_checker #(.DW(DW), .PROG_CYC(PROG_CYC)) u_pgb_checker (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .dout(dout),
  .dout_en(dout_en), .busy(busy), .page_err(page_err)
);

// File: tb/pgb_eeprom_ctrl_bench.sv
`timescale 1ns/1ps
module pgb_eeprom_ctrl_bench;
  localparam int AW = 16, DW = 8, PAGE_AW = 7, ARR_AW = 9;
  localparam int LW = 40, PC = 160, GM = 3;
  localparam int DEPTH = 1 << ARR_AW;

  logic clk = 1'b0, rst = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, busy, page_err;

  int checks = 0, fails = 0;
  logic [DW-1:0] model [DEPTH];

  always #4 clk = ~clk;

  pgb_eeprom_ctrl #(.AW(AW), .DW(DW), .PAGE_AW(PAGE_AW), .ARR_AW(ARR_AW),
                    .LOAD_WIN(LW), .PROG_CYC(PC), .GLITCH_MIN(GM)) u_pgb_eeprom_ctrl (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en), .busy(busy), .page_err(page_err)
  );

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 37 + (a >> 3) + 11);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [DW-1:0] d, int hold);
    tick(1);
    addr = AW'(a); din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    tick(hold);
    ce_n = 1'b1; we_n = 1'b1;
    tick(3);
  endtask

  task automatic rd(int a, output logic [DW-1:0] v, output logic en);
    tick(1);
    addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
    tick(4);
    v = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    tick(2);
  endtask

  task automatic wait_done(output int len);
    int g = 0;
    while (!busy && g < LW + 20) begin tick(1); g++; end
    len = 0;
    while (busy && len < PC + 20) begin tick(1); len++; end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_up();
  end

  initial begin
    logic [DW-1:0] v, v1, v2, v3;
    logic en;
    int len;
    tick(5);
    rst = 1'b0;
    tick(1);
    // R11 reset state
    chk(busy == 1'b0, "R11 busy", busy, 0);
    chk(page_err == 1'b0, "R11 page_err", page_err, 0);
    chk(dout_en == 1'b0, "R11 dout_en", dout_en, 0);
    chk(dout == '0, "R11 dout", dout, 0);

    // Fill every page fully, one session per page (R6, R10)
    for (int p = 0; p < DEPTH / 128; p++) begin
      for (int i = 0; i < 128; i++) begin
        wr(p * 128 + i, pat(p * 128 + i), 4);
        model[p * 128 + i] = pat(p * 128 + i);
      end
      wait_done(len);
      chk(len == PC, "R6 busy length", len, PC);
    end
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v, en);
      chk(v == model[a], "R10 readback", v, model[a]);
      if (a == 0) begin
        chk(en == 1'b1, "R10 dout_en during read", en, 1);
        chk(dout_en == 1'b0, "R10 dout_en after read", dout_en, 0);
      end
    end

    // R5 load window timing on a single-byte session
    tick(1);
    addr = 16'h0085; din = 8'h3C; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    tick(4);
    ce_n = 1'b1; we_n = 1'b1;
    tick(LW - 3);
    chk(busy == 1'b0, "R5 not yet programming", busy, 0);
    tick(2);
    chk(busy == 1'b1, "R5 programming started", busy, 1);
    model[16'h0085] = 8'h3C;

    // R8 / R9 status reads during programming
    rd(16'h0085, v1, en);
    rd(16'h0085, v2, en);
    rd(16'h0010, v3, en);
    chk(v1[7] == 1'b1, "R8 inverted bit7", v1[7], 1);
    chk(v1[5:0] == 6'd0, "R8 low bits zero", v1[5:0], 0);
    chk(v3[5:0] == 6'd0, "R8 low bits zero other addr", v3[5:0], 0);
    chk(v2[6] != v1[6], "R9 toggle 1", v2[6], !v1[6]);
    chk(v3[6] != v2[6], "R9 toggle 2", v3[6], !v2[6]);
    // R6 write during programming is ignored
    wr(16'h0086, 8'hEE, 4);
    chk(busy == 1'b1, "R6 still programming", busy, 1);
    wait_done(len);
    rd(16'h0085, v, en);
    chk(v == 8'h3C, "R9 true data after programming", v, 8'h3C);
    rd(16'h0086, v, en);
    chk(v == model[16'h0086], "R6 load during programming ignored", v, model[16'h0086]);
    // R7 rest of the page untouched
    for (int i = 0; i < 128; i++) begin
      rd(128 + i, v, en);
      chk(v == model[128 + i], "R7 page contents", v, model[128 + i]);
    end

    // R4 page lock
    wr(16'h0105, 8'h5A, 4);
    model[16'h0105] = 8'h5A;
    wr(16'h0185, 8'hA5, 4);
    chk(page_err == 1'b1, "R4 off-page flag", page_err, 1);
    wait_done(len);
    rd(16'h0105, v, en);
    chk(v == 8'h5A, "R4 in-page byte written", v, 8'h5A);
    rd(16'h0185, v, en);
    chk(v == model[16'h0185], "R4 off-page byte dropped", v, model[16'h0185]);

    // R3 short pulse filtered, threshold pulse accepted
    wr(16'h0020, 8'h77, GM - 1);
    tick(LW + 10);
    chk(busy == 1'b0, "R3 short pulse no session", busy, 0);
    rd(16'h0020, v, en);
    chk(v == model[16'h0020], "R3 short pulse no write", v, model[16'h0020]);
    wr(16'h0020, 8'h77, GM);
    model[16'h0020] = 8'h77;
    wait_done(len);
    rd(16'h0020, v, en);
    chk(v == 8'h77, "R3 threshold pulse written", v, 8'h77);

    // R1 inhibited combinations
    tick(1);
    addr = 16'h0030; din = 8'h11; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    tick(4);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tick(2);
    ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b1;
    tick(4);
    we_n = 1'b1;
    tick(LW + 10);
    chk(busy == 1'b0, "R1 no session", busy, 0);
    rd(16'h0030, v, en);
    chk(v == model[16'h0030], "R1 no write", v, model[16'h0030]);

    // R2 chip-select controlled write: late address capture, early data capture
    tick(1);
    addr = 16'h0040; din = 8'h01; oe_n = 1'b1; we_n = 1'b0;
    tick(2);
    ce_n = 1'b0;
    tick(1);
    addr = 16'h0041; din = 8'h02;
    tick(1);
    din = 8'h9B;
    tick(2);
    ce_n = 1'b1;
    tick(1);
    din = 8'h44;
    tick(1);
    we_n = 1'b1;
    tick(3);
    model[16'h0040] = 8'h9B;
    wait_done(len);
    rd(16'h0040, v, en);
    chk(v == 8'h9B, "R2 captured byte", v, 8'h9B);
    rd(16'h0041, v, en);
    chk(v == model[16'h0041], "R2 later address ignored", v, model[16'h0041]);

    chk(page_err == 1'b1, "R4 flag still set", page_err, 1);
    finish_up();
  end
endmodule